// File: doc/BRIEF.md
# Execute-to-Decode Forwarding Select and Load Interlock

This block steers operand forwarding for a five-stage in-order pipeline that forwards results fully. Each cycle it looks at the instruction in decode: its two source register fields, their read enables, its destination and its operation class. It compares these with the instruction that sits one stage ahead in execute. For each operand it chooses one source: the register file, the ALU result being produced in execute, or the return address of a link instruction in execute. It raises a stall when the decode operand cannot yet be supplied. With full forwarding, that happens only when a load in execute writes a register that decode reads.

The block keeps its own copy of the execute-stage destination and class. On each clock edge the decode instruction advances into this copy. When the stall is high, a bubble advances in its place, and the stalled decode instruction is expected to be presented again on the next cycle. The write enable of the execute stage has two parts. The forwarding part covers ALU and ALU-immediate results. The interlock part covers loads, plus link results when no separate link path exists. A parameter, `LINK_FWD`, chooses whether a link result is forwarded or causes a stall.

Top module: `fwd_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the execute stage holds a bubble. Both selects read 0 (register file) and stall is 0, whatever decode presents.
- R2: If execute holds class ALU (1) or ALU-immediate (2) with a nonzero destination equal to the first source field, and the first read enable is 1, the first select is 1 (ALU result).
- R3: The second select follows the same rule as R2, using the second source field and the second read enable.
- R4: If execute holds a load (class 3) with a nonzero destination equal to an enabled source field in decode, stall is 1 and both selects are 0.
- R5: The cycle after a stall, execute holds a bubble. Stall is then 0 and the re-presented decode instruction sees both selects at 0. A stalled instruction also never enters execute, so a later instruction cannot forward from it.
- R6: With LINK_FWD=1 (the default), if execute holds a link (class 4) with a nonzero destination equal to an enabled source, that operand's select is 2 (link address) and stall is 0.
- R7: Register 0 is never forwarded and never stalls, even when an instruction names it as its destination.
- R8: A source field whose read enable is 0 causes neither forwarding nor a stall, even when it matches the execute destination.
- R9: If execute holds a store (5), a branch (6) or a bubble (0), both selects are 0 and stall is 0.
- R10: With LINK_FWD=0, a link in execute whose nonzero destination matches an enabled source raises stall, and that operand's select stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_rs_i | input | AW | First source register of the decode instruction |
| dec_rt_i | input | AW | Second source register of the decode instruction |
| dec_re_a_i | input | 1 | First source is read |
| dec_re_b_i | input | 1 | Second source is read |
| dec_ws_i | input | AW | Destination register of the decode instruction |
| dec_cls_i | input | 3 | Operation class of the decode instruction |
| sel_a_o | output | 2 | First operand select: 0 register file, 1 ALU, 2 link |
| sel_b_o | output | 2 | Second operand select, same encoding |
| stall_o | output | 1 | Hold decode and send a bubble into execute |

## Verification
The hardest case to reach from the ports is the bubble inserted after a load interlock. It only appears when a load is followed at once by a dependent instruction that is then held in decode for a second cycle. The stimulus table includes two such pairs, one through each source field. Each stalled row is repeated so that the bubble in execute can be observed. The next row then depends on the held instruction, which shows that forwarding resumes. A second instance built with LINK_FWD=0 receives the same inputs and is checked on the link row.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [2:0] {
    CLS_NONE   = 3'd0,
    CLS_ALU    = 3'd1,
    CLS_ALUI   = 3'd2,
    CLS_LOAD   = 3'd3,
    CLS_LINK   = 3'd4,
    CLS_STORE  = 3'd5,
    CLS_BRANCH = 3'd6
  } op_cls_e;

  typedef enum logic [1:0] {
    SEL_RF   = 2'd0,
    SEL_ALU  = 2'd1,
    SEL_LINK = 2'd2
  } fwd_sel_e;

  // result ready at the end of execute, usable by the next instruction
  function automatic logic cls_fwd_ready(op_cls_e c);
    return (c == CLS_ALU) || (c == CLS_ALUI);
  endfunction

  // result only known after the memory stage
  function automatic logic cls_late(op_cls_e c);
    return c == CLS_LOAD;
  endfunction

  function automatic logic cls_link(op_cls_e c);
    return c == CLS_LINK;
  endfunction
endpackage

// File: rtl/fwd_exe_stage.sv
module fwd_exe_stage
  import fwd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_i,
  input  logic [AW-1:0] dec_ws_i,
  input  op_cls_e       dec_cls_i,
  output logic [AW-1:0] ex_ws_o,
  output logic          ex_fwd_we_o,
  output logic          ex_late_we_o,
  output logic          ex_link_we_o,
  output logic          ex_bubble_o
);
  op_cls_e       ex_cls_q;
  logic [AW-1:0] ex_ws_q;
  logic          ws_nz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_cls_q <= CLS_NONE;
      ex_ws_q  <= '0;
    end else if (hold_i) begin
      ex_cls_q <= CLS_NONE;
      ex_ws_q  <= '0;
    end else begin
      ex_cls_q <= dec_cls_i;
      ex_ws_q  <= dec_ws_i;
    end
  end

  assign ws_nz        = (ex_ws_q != '0);
  assign ex_ws_o      = ex_ws_q;
  assign ex_fwd_we_o  = cls_fwd_ready(ex_cls_q) && ws_nz;
  assign ex_late_we_o = cls_late(ex_cls_q) && ws_nz;
  assign ex_link_we_o = cls_link(ex_cls_q) && ws_nz;
  assign ex_bubble_o  = (ex_cls_q == CLS_NONE);

  // R5: a held decode instruction leaves a bubble behind it
  p_hold_bubble_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> ex_bubble_o && !ex_fwd_we_o && !ex_late_we_o);

  // R7: no enable part is ever raised for register 0
  p_zero_dest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_ws_o == '0) |-> !(ex_fwd_we_o || ex_late_we_o || ex_link_we_o));
endmodule

// File: rtl/fwd_operand.sv
module fwd_operand
  import fwd_pkg::*;
#(
  parameter int AW       = 5,
  parameter bit LINK_FWD = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] src_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] ex_ws_i,
  input  logic          ex_fwd_we_i,
  input  logic          ex_late_we_i,
  input  logic          ex_link_we_i,
  output fwd_sel_e      sel_o,
  output logic          hazard_o
);
  logic hit;
  assign hit = rd_en_i && (src_i == ex_ws_i);

  generate
    if (LINK_FWD) begin : g_link_path
      always_comb begin
        if (hit && ex_fwd_we_i)       sel_o = SEL_ALU;
        else if (hit && ex_link_we_i) sel_o = SEL_LINK;
        else                          sel_o = SEL_RF;
      end
      assign hazard_o = hit && ex_late_we_i;
    end else begin : g_link_stall
      assign sel_o    = (hit && ex_fwd_we_i) ? SEL_ALU : SEL_RF;
      assign hazard_o = hit && (ex_late_we_i || ex_link_we_i);
    end
  endgenerate

  // R8: an unread source takes no part
  p_unread_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |-> (sel_o == SEL_RF) && !hazard_o);

  // R7: register 0 as a source is always read from the file
  p_src_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i == '0) |-> (sel_o == SEL_RF) && !hazard_o);
endmodule

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
  import fwd_pkg::*;
#(
  parameter int AW       = 5,
  parameter bit LINK_FWD = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] dec_rs_i,
  input  logic [AW-1:0] dec_rt_i,
  input  logic          dec_re_a_i,
  input  logic          dec_re_b_i,
  input  logic [AW-1:0] dec_ws_i,
  input  logic [2:0]    dec_cls_i,
  output logic [1:0]    sel_a_o,
  output logic [1:0]    sel_b_o,
  output logic          stall_o
);
  localparam int NOPS = 2;

  logic [AW-1:0] ex_ws;
  logic          ex_fwd_we, ex_late_we, ex_link_we, ex_bubble;
  logic [AW-1:0] src   [NOPS];
  logic          rd_en [NOPS];
  fwd_sel_e      sel   [NOPS];
  logic [NOPS-1:0] hazard;

  assign src[0]   = dec_rs_i;
  assign src[1]   = dec_rt_i;
  assign rd_en[0] = dec_re_a_i;
  assign rd_en[1] = dec_re_b_i;

  fwd_exe_stage #(.AW(AW)) u_exe (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_i      (stall_o),
    .dec_ws_i    (dec_ws_i),
    .dec_cls_i   (op_cls_e'(dec_cls_i)),
    .ex_ws_o     (ex_ws),
    .ex_fwd_we_o (ex_fwd_we),
    .ex_late_we_o(ex_late_we),
    .ex_link_we_o(ex_link_we),
    .ex_bubble_o (ex_bubble)
  );

  for (genvar g = 0; g < NOPS; g++) begin : g_opnd
    fwd_operand #(.AW(AW), .LINK_FWD(LINK_FWD)) u_opnd (
      .clk         (clk),
      .rst_n       (rst_n),
      .src_i       (src[g]),
      .rd_en_i     (rd_en[g]),
      .ex_ws_i     (ex_ws),
      .ex_fwd_we_i (ex_fwd_we),
      .ex_late_we_i(ex_late_we),
      .ex_link_we_i(ex_link_we),
      .sel_o       (sel[g]),
      .hazard_o    (hazard[g])
    );
  end

  assign stall_o = |hazard;
  assign sel_a_o = sel[0];
  assign sel_b_o = sel[1];

  // R9: an empty execute stage forwards nothing and interlocks nothing
  p_bubble_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ex_bubble |-> (sel_a_o == 2'd0) && (sel_b_o == 2'd0) && !stall_o);

  // R5: a stall never lasts two cycles in a row
  p_stall_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> !stall_o && (sel_a_o == 2'd0) && (sel_b_o == 2'd0));

  // R4: a dependent read behind a load with a real destination interlocks
  p_load_use_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_late_we && dec_re_a_i && (dec_rs_i == ex_ws)) |-> stall_o);

  // R4: an interlocked instruction is not also given a forwarded operand
  p_stall_no_fwd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> (sel_a_o == 2'd0) && (sel_b_o == 2'd0));
endmodule

// File: tb/fwd_ctrl_tb.sv
module fwd_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] rs, rt, ws;
  logic       ea, eb;
  logic [2:0] cls;
  logic [1:0] sa, sb, sa_n, sb_n;
  logic       st, st_n;
  int         n_chk = 0;
  int         n_bad = 0;

  always #5 clk = ~clk;

  fwd_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .dec_rs_i(rs), .dec_rt_i(rt),
    .dec_re_a_i(ea), .dec_re_b_i(eb), .dec_ws_i(ws), .dec_cls_i(cls),
    .sel_a_o(sa), .sel_b_o(sb), .stall_o(st));

  fwd_ctrl #(.LINK_FWD(1'b0)) u_dut_nolink (
    .clk(clk), .rst_n(rst_n), .dec_rs_i(rs), .dec_rt_i(rt),
    .dec_re_a_i(ea), .dec_re_b_i(eb), .dec_ws_i(ws), .dec_cls_i(cls),
    .sel_a_o(sa_n), .sel_b_o(sb_n), .stall_o(st_n));

  typedef struct packed {
    logic [4:0] rs; logic [4:0] rt; logic ea; logic eb;
    logic [4:0] ws; logic [2:0] cls;
    logic [1:0] xa; logic [1:0] xb; logic xs; logic [3:0] req;
  } vec_t;

  // classes: 0 none, 1 alu, 2 alu-imm, 3 load, 4 link, 5 store, 6 branch
  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{5'd1, 5'd2, 1'b1,1'b1, 5'd5, 3'd1, 2'd0,2'd0,1'b0, 4'd1},  // R1 empty exe
    '{5'd5, 5'd9, 1'b1,1'b0, 5'd6, 3'd2, 2'd1,2'd0,1'b0, 4'd2},  // R2
    '{5'd1, 5'd6, 1'b1,1'b1, 5'd7, 3'd1, 2'd0,2'd1,1'b0, 4'd3},  // R3 from alu-imm
    '{5'd7, 5'd7, 1'b1,1'b1, 5'd0, 3'd5, 2'd1,2'd1,1'b0, 4'd2},  // R2 both
    '{5'd3, 5'd0, 1'b1,1'b0, 5'd8, 3'd3, 2'd0,2'd0,1'b0, 4'd9},  // R9 store
    '{5'd8, 5'd2, 1'b1,1'b1, 5'd9, 3'd1, 2'd0,2'd0,1'b1, 4'd4},  // R4 via rs
    '{5'd8, 5'd2, 1'b1,1'b1, 5'd9, 3'd1, 2'd0,2'd0,1'b0, 4'd5},  // R5 held
    '{5'd0, 5'd0, 1'b0,1'b0, 5'd31,3'd4, 2'd0,2'd0,1'b0, 4'd8},
    '{5'd31,5'd31,1'b1,1'b1, 5'd10,3'd1, 2'd2,2'd2,1'b0, 4'd6},  // R6
    '{5'd10,5'd0, 1'b1,1'b0, 5'd0, 3'd1, 2'd1,2'd0,1'b0, 4'd2},
    '{5'd0, 5'd0, 1'b1,1'b1, 5'd11,3'd1, 2'd0,2'd0,1'b0, 4'd7},  // R7 alu to r0
    '{5'd11,5'd0, 1'b1,1'b0, 5'd0, 3'd3, 2'd1,2'd0,1'b0, 4'd2},
    '{5'd0, 5'd0, 1'b1,1'b1, 5'd3, 3'd1, 2'd0,2'd0,1'b0, 4'd7},  // R7 load to r0
    '{5'd0, 5'd0, 1'b0,1'b0, 5'd4, 3'd3, 2'd0,2'd0,1'b0, 4'd7},
    '{5'd4, 5'd4, 1'b0,1'b0, 5'd0, 3'd6, 2'd0,2'd0,1'b0, 4'd8},  // R8
    '{5'd1, 5'd4, 1'b1,1'b1, 5'd0, 3'd5, 2'd0,2'd0,1'b0, 4'd9},  // R9 branch
    '{5'd0, 5'd0, 1'b0,1'b0, 5'd12,3'd3, 2'd0,2'd0,1'b0, 4'd9},
    '{5'd3, 5'd12,1'b1,1'b1, 5'd1, 3'd1, 2'd0,2'd0,1'b1, 4'd4},  // R4 via rt
    '{5'd3, 5'd12,1'b1,1'b1, 5'd1, 3'd1, 2'd0,2'd0,1'b0, 4'd5},  // R5 held
    '{5'd1, 5'd0, 1'b1,1'b0, 5'd2, 3'd1, 2'd1,2'd0,1'b0, 4'd5}   // R5 resumes
  };

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] a, input logic [4:0] b, input logic xa,
                       input logic xb, input logic [4:0] w, input logic [2:0] c);
    rs = a; rt = b; ea = xa; eb = xb; ws = w; cls = c;
  endtask

  initial begin
    drive(5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 3'd0);
    repeat (3) @(negedge clk);
    // R1: state during reset with a matching-looking decode
    drive(5'd4, 5'd4, 1'b1, 1'b1, 5'd4, 3'd3);
    #2 check("R1", {st, sa, sb}, 5'd0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].rs, VECS[i].rt, VECS[i].ea, VECS[i].eb, VECS[i].ws, VECS[i].cls);
      #2;
      check($sformatf("R%0d row%0d", VECS[i].req, i), {st, sa, sb},
            {VECS[i].xs, VECS[i].xa, VECS[i].xb});
      if (i == 8) check("R10 link stall", {st_n, sa_n, sb_n}, 5'b1_00_00);
      @(negedge clk);
    end
    // R1: reset in the middle clears a pending load
    drive(5'd0, 5'd0, 1'b0, 1'b0, 5'd13, 3'd3);
    @(negedge clk);
    rst_n = 1'b0;
    drive(5'd13, 5'd0, 1'b1, 1'b0, 5'd2, 3'd1);
    #2 check("R1 in reset", {st, sa, sb}, 5'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #2 check("R1 after reset", {st, sa, sb}, 5'd0);
    // R2: alu-immediate through rs while rt is unread
    @(negedge clk);
    drive(5'd0, 5'd0, 1'b0, 1'b0, 5'd20, 3'd2);
    @(negedge clk);
    drive(5'd20, 5'd20, 1'b1, 1'b0, 5'd0, 3'd5);
    #2 check("R2 alui", {st, sa, sb}, 5'b0_01_00);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule